// File: doc/BRIEF.md
# Interleaved Multi-Converter Capture and Readout Sequencer

This block runs a deep-capture front end in which several converters share one base clock. Each converter takes its turn in a rotating phase, so each one runs at a fraction of the aggregate rate. Each converter owns a RAM bank. All banks share one address counter. A phase counter selects the bank that is written on each base clock, and the shared address moves forward once every bank has taken a sample at the current location.

A host-driven mode line selects the operating mode:

- **Capture:** the banks fill until the last location has been written. The block then stops and raises its done flag.
- **Dump:** the banks are read back one sample per host strobe over a slow handshake. At each address the banks are read in phase order, so the samples come out in the order they were taken. The done flag rises once the final sample has been stepped past.

Any change of mode rewinds the address and the phase to the first sample and clears done.

Top module: `ilv_capture_sequencer`

## Requirements
- R1: While rst_n is low (synchronous, active low), bank_we is all zero, addr is 0, done is 0 and dump_data is 0. After release the block is in capture mode at address 0, phase 0.
- R2: In capture mode, at most one bank_we bit is high in any cycle. On successive cycles the active bit rotates through banks 0, 1, ..., NUM_ADC-1 and then back to 0.
- R3: When bank_we[k] is high at a clock edge, bank k stores adc_data[k*DATA_W +: DATA_W] at location addr.
- R4: The shared address increments by one on the edge at which bank NUM_ADC-1 is written, and holds on all other edges.
- R5: The edge that writes bank NUM_ADC-1 at the last address (2**ADDR_W-1) sets done. While done is set in capture mode, no bank is written and addr holds.
- R6: In dump mode, dump_data shows the sample at the current read position. Positions run address-major, with banks 0 to NUM_ADC-1 at each address, which is the order in which the samples were taken.
- R7: In dump mode, each rising edge of dump_strobe advances the read position by exactly one sample. A strobe held high for several cycles counts once.
- R8: In dump mode, a strobe rising edge at the final position sets done. The position then holds, and further strobes have no effect.
- R9: On the first edge at which dump_mode differs from the mode in effect, addr and phase reset to 0 and done clears. No bank is written in that cycle.
- R10: While dump_mode is 1 (dump), bank_we is all zero.
- R11: In capture mode, dump_strobe has no effect on addr or on the write sequence, and dump_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dump_mode | input | 1 | 0 = capture, 1 = dump |
| adc_data | input | NUM_ADC*DATA_W | Converter samples; converter k in slice k |
| dump_strobe | input | 1 | Host read strobe; each rising edge steps one sample |
| bank_we | output | NUM_ADC | Per-bank write enables |
| addr | output | ADDR_W | Shared bank address |
| dump_data | output | DATA_W | Sample at the current read position (0 in capture mode) |
| done | output | 1 | Current mode has run to its last sample |

## Verification
The embedded properties check the following on every cycle:

- the write enables are one-hot or zero;
- no write happens in dump mode or after capture has finished;
- the address steps only after the last bank is written, or only on a strobe edge;
- done is sticky;
- a mode change rewinds the counters.

Some behaviours need the bench scenarios, which compare against a time-indexed sample model:

- that each bank holds the right converter's data;
- that readout reproduces true sample order, including after a partial recapture overwrites part of a full one;
- that held strobes and strobes in capture mode leave the sequence alone.

// File: rtl/ilv_seq_pkg.sv
// Package: shared mode encoding for the interleaved capture sequencer.
// Assumes: dump_mode input uses 0 = capture, 1 = dump.
package ilv_seq_pkg;
    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_DUMP    = 1'b1
    } seq_mode_e;
endpackage

// File: rtl/ilv_seq_counter.sv
// Phase and shared-address counter.
// The phase rotates over NUM_ADC banks. The address steps when the phase wraps.
// clear has priority over advance.
// Assumes: NUM_ADC is a power of two, at least 2.
module ilv_seq_counter #(
    parameter int NUM_ADC = 4,
    parameter int ADDR_W  = 4,
    localparam int PH_W   = $clog2(NUM_ADC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [PH_W-1:0]   phase,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(NUM_ADC - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

    logic phase_wrap;

    // Flag the phase that completes one address row.
    assign phase_wrap = (phase == PH_LAST);

    // Flag the final sample position.
    assign at_last = phase_wrap && (addr == ADDR_LAST);

    // Rotate the phase and step the address at each phase wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase <= '0;
            addr  <= '0;
        end else if (advance) begin
            if (phase_wrap) begin
                phase <= '0;
                addr  <= addr + ADDR_W'(1);
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end

    // R4: address steps only when the last phase advances.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && phase_wrap) |=> (addr == $past(addr) + ADDR_W'(1)));

    // R4: address holds on any non-wrapping step.
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(advance && phase_wrap)) |=> $stable(addr));

    // R9: a clear rewinds both counters.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (addr == '0 && phase == '0));
endmodule

// File: rtl/ilv_bank_array.sv
// One RAM bank per converter.
// Bank k writes its own converter slice at the shared address.
// Readout selects one bank at the shared address.
// Assumes: the write enables are one-hot or zero; banks have no reset.
module ilv_bank_array #(
    parameter int NUM_ADC = 4,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    localparam int PH_W   = $clog2(NUM_ADC),
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_ADC-1:0]        we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_ADC*DATA_W-1:0] wdata,
    input  logic [PH_W-1:0]           rd_bank,
    output logic [DATA_W-1:0]         rd_data
);
    logic [DATA_W-1:0] bank_out [NUM_ADC];

    for (genvar k = 0; k < NUM_ADC; k++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        // Store converter k's sample when this bank is enabled.
        always_ff @(posedge clk) begin
            if (we[k]) mem[addr] <= wdata[k*DATA_W +: DATA_W];
        end

        // Present this bank's word at the shared address.
        assign bank_out[k] = mem[addr];
    end

    // Select the bank named by the read phase.
    assign rd_data = bank_out[rd_bank];

    // R2: never more than one bank written per edge.
    p_we_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));
endmodule

// File: rtl/ilv_capture_sequencer.sv
// Top level of the interleaved capture and readout sequencer.
// - Capture: banks are written in rotating phase until the last address is full.
// - Dump: one sample per strobe rising edge, in time order.
// - A change of mode rewinds the counters and clears done.
// Assumes: dump_mode is synchronous to clk; dump_strobe is a slow level signal.
module ilv_capture_sequencer
    import ilv_seq_pkg::*;
#(
    parameter int NUM_ADC = 4,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    localparam int PH_W   = $clog2(NUM_ADC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dump_mode,
    input  logic [NUM_ADC*DATA_W-1:0] adc_data,
    input  logic                      dump_strobe,
    output logic [NUM_ADC-1:0]        bank_we,
    output logic [ADDR_W-1:0]         addr,
    output logic [DATA_W-1:0]         dump_data,
    output logic                      done
);
    seq_mode_e         mode_q;
    logic              strobe_q;
    logic              mode_change;
    logic              cap_active;
    logic              strobe_rise;
    logic              step_req;
    logic              advance;
    logic              done_set;
    logic              at_last;
    logic [PH_W-1:0]   phase;
    logic [DATA_W-1:0] rd_data;

    // Detect a request to switch modes.
    assign mode_change = (seq_mode_e'(dump_mode) != mode_q);

    // Capture runs only while settled in capture mode and not finished.
    assign cap_active = rst_n && !mode_change && (mode_q == MODE_CAPTURE) && !done;

    // Rising edge of the host strobe.
    assign strobe_rise = dump_strobe && !strobe_q;

    // One step is wanted per write in capture, or per strobe edge in dump.
    assign step_req = cap_active ||
                      (!mode_change && (mode_q == MODE_DUMP) && !done && strobe_rise);

    // Move forward unless at the last position; there, finish instead.
    assign advance  = step_req && !at_last;
    assign done_set = step_req && at_last;

    // Remember the mode in effect and the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_CAPTURE;
            strobe_q <= 1'b0;
        end else begin
            mode_q   <= seq_mode_e'(dump_mode);
            strobe_q <= dump_strobe;
        end
    end

    // Sticky done, cleared by a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_change) done <= 1'b0;
        else if (done_set)         done <= 1'b1;
    end

    ilv_seq_counter #(
        .NUM_ADC (NUM_ADC),
        .ADDR_W  (ADDR_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (mode_change),
        .advance (advance),
        .phase   (phase),
        .addr    (addr),
        .at_last (at_last)
    );

    // Decode the phase into one write enable per bank.
    for (genvar k = 0; k < NUM_ADC; k++) begin : g_we
        assign bank_we[k] = cap_active && (phase == PH_W'(k));
    end

    ilv_bank_array #(
        .NUM_ADC (NUM_ADC),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bank_we),
        .addr    (addr),
        .wdata   (adc_data),
        .rd_bank (phase),
        .rd_data (rd_data)
    );

    // Readout is visible only once dump mode is in effect.
    assign dump_data = (mode_q == MODE_DUMP) ? rd_data : '0;

    // R10: no write while dump is requested.
    p_no_write_dump_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dump_mode |-> (bank_we == '0));

    // R5: a finished capture writes nothing.
    p_full_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bank_we == '0));

    // R5: done holds until the mode changes.
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_change) |=> done);

    // R9: a mode change clears done on the next cycle.
    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |=> !done);

    // R7: in dump, the address moves only after a strobe edge.
    p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_DUMP) && !mode_change && !strobe_rise) |=> $stable(addr));

    // R11: in capture the address moves only after a write.
    p_strobe_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_CAPTURE) && !mode_change && (bank_we == '0)) |=> $stable(addr));
endmodule

// File: tb/tb_ilv_capture_sequencer.sv
`timescale 1ns/1ps
module tb_ilv_capture_sequencer;
    localparam int N     = 4;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int TOTAL = N * DEPTH;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dump_mode = 1'b0;
    logic [N*DW-1:0] adc_data = '0;
    logic            dump_strobe = 1'b0;
    logic [N-1:0]    bank_we;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   dump_data;
    logic            done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // Behavioural model: a linear sample index plus a time-indexed store.
    int m_pos, m_done, m_modeq, m_strq;
    int m_mem [TOTAL];

    ilv_capture_sequencer #(.NUM_ADC(N), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .dump_mode(dump_mode), .adc_data(adc_data),
        .dump_strobe(dump_strobe), .bank_we(bank_we), .addr(addr),
        .dump_data(dump_data), .done(done)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int sample_of(input int c, input int k);
        return (c * 7 + k * 61 + 3) & 255;
    endfunction

    // One base cycle: drive at negedge, compare, then advance the model.
    task automatic step(input bit mode, input bit strb, input string tag);
        logic [N-1:0] exp_we;
        int           exp_data;
        bit           cap;
        @(negedge clk);
        rst_n       = 1'b1;
        dump_mode   = mode;
        dump_strobe = strb;
        for (int k = 0; k < N; k++) adc_data[k*DW +: DW] = DW'(sample_of(cyc, k));
        #1;
        cap      = !mode && (m_modeq == 0) && (m_done == 0);
        exp_we   = cap ? N'(1 << (m_pos % N)) : '0;
        exp_data = (m_modeq != 0) ? m_mem[m_pos] : 0;
        check(bank_we == exp_we, {tag, mode ? "/R10" : "/R2"}, "bank_we", int'(bank_we), int'(exp_we));
        check(int'(addr) == m_pos / N, {tag, "/R4"}, "addr", int'(addr), m_pos / N);
        check(int'(done) == m_done, {tag, mode ? "/R8" : "/R5"}, "done", int'(done), m_done);
        check(int'(dump_data) == exp_data, {tag, m_modeq != 0 ? "/R6" : "/R11"}, "dump_data",
              int'(dump_data), exp_data);
        if (int'(mode) != m_modeq) begin
            m_pos = 0; m_done = 0; m_modeq = int'(mode);
        end else if (!mode) begin
            if (m_done == 0) begin
                m_mem[m_pos] = sample_of(cyc, m_pos % N);
                if (m_pos == TOTAL - 1) m_done = 1; else m_pos++;
            end
        end else if (strb && (m_strq == 0) && (m_done == 0)) begin
            if (m_pos == TOTAL - 1) m_done = 1; else m_pos++;
        end
        m_strq = int'(strb);
        cyc++;
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_pos = 0; m_done = 0; m_modeq = 0; m_strq = 0;
        for (int i = 0; i < TOTAL; i++) m_mem[i] = 0;
        // R1: outputs quiet while reset is held.
        repeat (3) begin
            @(negedge clk);
            rst_n = 1'b0;
            #1;
            check(bank_we == '0, "R1", "bank_we", int'(bank_we), 0);
            check(addr == '0, "R1", "addr", int'(addr), 0);
            check(done == 1'b0, "R1", "done", int'(done), 0);
            check(dump_data == '0, "R1", "dump_data", int'(dump_data), 0);
        end
        // R2 R3 R4 R5 R11: full capture with stray strobes, run past the end.
        for (int i = 0; i < TOTAL + 8; i++) step(1'b0, (i % 3) == 0, "cap");
        // R6 R7 R8 R9: dump with spaced pulses, one long pulse, extra strobes past the end.
        step(1'b1, 1'b0, "R9");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R7hold");
        step(1'b1, 1'b0, "R7hold");
        for (int i = 0; i < TOTAL + 4; i++) begin
            step(1'b1, 1'b1, "dump");
            step(1'b1, 1'b0, "dump");
            if (i % 4 == 0) step(1'b1, 1'b0, "dump");
        end
        // R9 R3: back to capture part-way, then dump to see new and old samples.
        step(1'b0, 1'b0, "R9");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "recap");
        step(1'b1, 1'b0, "R9");
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b1, "redump");
            step(1'b1, 1'b0, "redump");
        end
        // R9: switch in mid-dump rewinds again.
        step(1'b0, 1'b0, "R9");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R11");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule